// File: doc/BRIEF.md
# Trim Setting Register with Non-Volatile Store Controller

This block holds a 7-bit trim code that steers a current DAC, and keeps a non-volatile copy of it. Write beats come from a serial front end over a valid/ready channel. Each beat carries a code and a destination bit. With the destination bit set, only the working register changes. With it clear, the working register changes and a store of the code into non-volatile memory is also requested. The non-volatile memory is modelled here as a register that keeps its contents across `rst_n`. A store into it takes a parameterised number of clock cycles. At the default of 25,000,000 cycles at 100 MHz, this is 250 ms.

An unlock pin gates the store path. When the pin is low or left floating (the board holds it low through a pull-down), stores never start. The block drives the inverse of that pin on a separate output. It also drives a select that tells the clock-switching logic to take the alternate serial clock input instead of the main one. The select is high while the pin is high; the clock multiplexer itself sits outside this block. After every reset release, the stored code is copied into the working register before the code is marked valid. A ready status reads 0 while a store is in progress and returns to 1 when the store completes.

Write channel rules: `wr_ready` is low from reset until the power-on copy has happened, and high from then on. It is never lowered for back-pressure, including while a store is in progress. A beat transfers on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_valid` is ignored while `wr_ready` is low.

Top module: `trim_nvm_ctrl`

## Requirements
- R1: On the first clock edge after `rst_n` is released, `setting` is loaded with the stored non-volatile code and `setting_valid` and `wr_ready` rise. Before that edge, both are 0 and `setting` is 0.
- R2: A beat with `wr_reg_only`=1 sets `setting` to `wr_value` on its transfer edge and starts no store: `prog_ready` stays 1.
- R3: A beat with `wr_reg_only`=0, accepted while `nvm_unlock`=1 and `prog_ready`=1, sets `setting` on its transfer edge and drives `prog_ready` to 0 on that edge. `prog_ready` stays 0 for exactly PROG_CYCLES cycles and then returns to 1. From then on, the stored code equals that beat's `wr_value`.
- R4: While `nvm_unlock`=0, a beat with `wr_reg_only`=0 still sets `setting`, starts no store (`prog_ready` stays 1), and leaves the stored code unchanged.
- R5: A beat with `wr_reg_only`=0 accepted while `prog_ready`=0 sets `setting`. Its store part is dropped: the running store keeps its end time and its code.
- R6: `unlock_inv` is always the logical inverse of `nvm_unlock`.
- R7: `alt_clk_sel` is 1 exactly when `nvm_unlock` is 1, selecting the alternate serial clock.
- R8: `wr_valid` is ignored while `wr_ready` is 0, and `wr_ready` stays 1 during a store.
- R9: Asserting `rst_n` during a store aborts it: the stored code keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset; does not clear the stored code |
| wr_valid | input | 1 | Write beat present |
| wr_ready | output | 1 | Write beat can be taken |
| wr_value | input | SET_W | Trim code carried by the beat |
| wr_reg_only | input | 1 | 1: working register only; 0: register and store |
| nvm_unlock | input | 1 | High permits stores and selects the alternate clock |
| unlock_inv | output | 1 | Inverse of `nvm_unlock` |
| alt_clk_sel | output | 1 | High routes the alternate serial clock onto the clock path |
| setting | output | SET_W | Current trim code to the DAC |
| setting_valid | output | 1 | Trim code has been loaded since reset |
| prog_ready | output | 1 | 0 while a store is in progress |

## Verification
The embedded assertions check these rules on every cycle:
- every accepted beat lands in `setting` one edge later;
- register-only beats and locked beats never raise busy;
- a store keeps busy until its countdown ends;
- the stored code changes only on a store's final edge;
- the power-on copy matches the stored code.

The bench's scenarios show the things no single-cycle property can. These are the exact busy length, the retained code seen through a later reset, a second store request dropped during busy, an aborted store, and beats ignored before the load.

// File: rtl/trim_pkg.sv
package trim_pkg;
  typedef enum logic {
    DEST_BOTH     = 1'b0,
    DEST_REG_ONLY = 1'b1
  } dest_e;

  function automatic int cnt_width(input longint unsigned n);
    int w;
    w = 1;
    while ((64'd1 << w) <= n) w++;
    return w;
  endfunction
endpackage

// File: rtl/trim_prog_timer.sv
module trim_prog_timer #(
  parameter int unsigned CYCLES = 25_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic last
);
  localparam int CNT_W = trim_pkg::cnt_width(CYCLES);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (start && !busy)   cnt_q <= LOAD;
    else if (busy)             cnt_q <= cnt_q - ONE;
  end

  assign busy = (cnt_q != '0);
  assign last = (cnt_q == ONE);

  // R3: a started store stays busy until its final cycle
  assert_busy_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> busy);
  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

// File: rtl/trim_nvm_cell.sv
module trim_nvm_cell #(
  parameter int unsigned SET_W    = 7,
  parameter logic [SET_W-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [SET_W-1:0] din,
  input  logic             commit,
  output logic [SET_W-1:0] dout
);
  logic [SET_W-1:0] pend_q;
  logic [SET_W-1:0] cell_q = INIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (capture) pend_q <= din;
  end

  always_ff @(posedge clk) begin
    if (commit) cell_q <= pend_q;
  end

  assign dout = cell_q;

  // R9: stored code only moves on the final edge of a store
  assert_cell_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(cell_q));
endmodule

// File: rtl/trim_nvm_ctrl.sv
module trim_nvm_ctrl #(
  parameter int unsigned SET_W       = 7,
  parameter int unsigned PROG_CYCLES = 25_000_000,
  parameter logic [SET_W-1:0] NVM_INIT = 7'h40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [SET_W-1:0] wr_value,
  input  logic             wr_reg_only,
  input  logic             nvm_unlock,
  output logic             unlock_inv,
  output logic             alt_clk_sel,
  output logic [SET_W-1:0] setting,
  output logic             setting_valid,
  output logic             prog_ready
);
  import trim_pkg::*;

  logic             loaded_q;
  logic [SET_W-1:0] setting_q;
  logic [SET_W-1:0] stored;
  logic             accept, store_go, busy, last;
  dest_e            dest;

  assign dest     = dest_e'(wr_reg_only);
  assign accept   = wr_valid && loaded_q;
  assign store_go = accept && (dest == DEST_BOTH) && nvm_unlock;

  trim_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(store_go), .busy(busy), .last(last)
  );

  trim_nvm_cell #(.SET_W(SET_W), .INIT(NVM_INIT)) u_cell (
    .clk(clk), .rst_n(rst_n), .capture(store_go && !busy), .din(wr_value),
    .commit(last), .dout(stored)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q  <= 1'b0;
      setting_q <= '0;
    end else if (!loaded_q) begin
      loaded_q  <= 1'b1;
      setting_q <= stored;
    end else if (accept) begin
      setting_q <= wr_value;
    end
  end

  assign wr_ready      = loaded_q;
  assign setting       = setting_q;
  assign setting_valid = loaded_q;
  assign prog_ready    = !busy;
  assign unlock_inv    = !nvm_unlock;
  assign alt_clk_sel   = nvm_unlock;

  // R1: power-on copy matches the stored code
  assert_load_copy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loaded_q) |-> (setting_q == stored));
  // R8: every accepted beat lands in the register
  assert_beat_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (setting == $past(wr_value)));
  // R2: register-only beats never raise busy
  assert_reg_only_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_reg_only && prog_ready) |=> prog_ready);
  // R4: locked beats never raise busy
  assert_locked_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !nvm_unlock && prog_ready) |=> prog_ready);
endmodule

// File: tb/trim_nvm_ctrl_bench.sv
module trim_nvm_ctrl_bench;
  localparam int unsigned W  = 7;
  localparam int unsigned PC = 8;
  localparam logic [W-1:0] INIT = 7'h15;

  logic clk = 0, rst_n = 0, wr_valid = 0, wr_reg_only = 1, nvm_unlock = 0;
  logic [W-1:0] wr_value = '0;
  logic wr_ready, unlock_inv, alt_clk_sel, setting_valid, prog_ready;
  logic [W-1:0] setting;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  trim_nvm_ctrl #(.SET_W(W), .PROG_CYCLES(PC), .NVM_INIT(INIT)) u_trim_nvm_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_value(wr_value), .wr_reg_only(wr_reg_only), .nvm_unlock(nvm_unlock),
    .unlock_inv(unlock_inv), .alt_clk_sel(alt_clk_sel), .setting(setting),
    .setting_valid(setting_valid), .prog_ready(prog_ready)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic beat(input logic unl, input logic reg_only, input logic [W-1:0] v);
    nvm_unlock = unl; wr_reg_only = reg_only; wr_value = v; wr_valid = 1;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    chk("R1 valid low in reset", setting_valid, 0);
    chk("R1 setting zero in reset", setting, 0);
    rst_n = 1;
    @(negedge clk);
  endtask

  // {unlock, reg_only, expect_busy, value}
  localparam logic [9:0] VEC [6] = '{
    {1'b1, 1'b1, 1'b0, 7'h05},
    {1'b0, 1'b0, 1'b0, 7'h7F},
    {1'b1, 1'b0, 1'b1, 7'h00},
    {1'b0, 1'b1, 1'b0, 7'h33},
    {1'b1, 1'b0, 1'b1, 7'h6A},
    {1'b0, 1'b0, 1'b0, 7'h11}
  };

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 load from store", setting, INIT);
    chk("R1 valid after load", setting_valid, 1);
    chk("R8 ready after load", wr_ready, 1);

    nvm_unlock = 0; #1;
    chk("R6 inverse low", unlock_inv, 1);
    chk("R7 select low", alt_clk_sel, 0);
    nvm_unlock = 1; #1;
    chk("R6 inverse high", unlock_inv, 0);
    chk("R7 select high", alt_clk_sel, 1);

    for (int i = 0; i < 6; i++) begin
      beat(VEC[i][9], VEC[i][8], VEC[i][6:0]);
      chk("R2/R3/R4 setting", setting, VEC[i][6:0]);
      chk("R2/R3/R4 ready", prog_ready, !VEC[i][7]);
      if (VEC[i][7]) begin
        chk("R8 ready during store", wr_ready, 1);
        repeat (PC - 1) @(negedge clk);
        chk("R3 still busy at last cycle", prog_ready, 0);
        @(negedge clk);
        chk("R3 ready after store", prog_ready, 1);
      end
    end

    // stored code is last successful store (R4 beats did not change it)
    do_reset();
    chk("R4 stored unchanged by locked beat", setting, 7'h6A);

    // R5: second store during busy is dropped
    beat(1, 0, 7'h22);
    repeat (2) @(negedge clk);
    beat(1, 0, 7'h44);
    chk("R5 setting updated during busy", setting, 7'h44);
    repeat (PC - 4) @(negedge clk);
    chk("R5 end time unchanged busy", prog_ready, 0);
    @(negedge clk);
    chk("R5 end time unchanged ready", prog_ready, 1);
    do_reset();
    chk("R5 store keeps first code", setting, 7'h22);

    // R9: reset mid-store aborts it
    beat(1, 0, 7'h5C);
    repeat (3) @(negedge clk);
    rst_n = 0; @(negedge clk);
    rst_n = 1; @(negedge clk);
    chk("R9 aborted store keeps code", setting, 7'h22);
    chk("R9 ready after abort", prog_ready, 1);

    // R8: valid ignored before load
    rst_n = 0; wr_valid = 1; wr_reg_only = 1; wr_value = 7'h2B;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    wr_valid = 0;
    chk("R8 beat ignored before load", setting, 7'h22);
    @(negedge clk);
    chk("R8 no late transfer", setting, 7'h22);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule